// File: doc/BRIEF.md
# Out-of-Order Issue Scoreboard Controller

This controller tracks hazards for a core that has five non-pipelined execution units: one integer/load unit, two multipliers, one adder/subtracter and one divider. Decoded instructions arrive one at a time over a valid/ready handshake. Each carries an operation class, a destination register and two source registers. Instructions issue strictly in program order. Once issued, they may read operands, execute and retire their results out of order.

The block keeps a status entry per execution unit. Each entry holds busy, a waiting-to-read flag, the class, the destination register, both source registers, the unit that will produce each source, and a ready flag per source. It also keeps a table mapping each architectural register to the unit that will write it next. Issue is refused on a structural or write-after-write conflict. Operand reads wait until both sources are ready. A finished unit may not write while another unit still has to read the old value of that register. Countdown stubs take the place of the arithmetic units. A start strobe launches each stub, and its finish flag holds until the write-back is granted.

Unit identifiers are 1 (integer), 2 (multiply 1), 3 (multiply 2), 4 (add) and 5 (divide). The value 0 means "no unit". The class encoding is 0 integer/load, 1 multiply, 2 add/subtract and 3 divide.

Top module: `hazard_scoreboard`

## Requirements
- R1: `inReady` is high exactly when the presented class has an idle unit and no unit is pending on the presented destination. An instruction issues in a cycle where `inValid` and `inReady` are both high. A refused instruction blocks all later ones.
- R2: On issue, `issueUnit` names the unit taken. For multiply, the lower-numbered idle unit (2 before 3) is chosen. `issueUnit` is 0 when nothing issues.
- R3: An instruction whose destination is still pending for any unit does not issue until that unit's write-back has completed.
- R4: `readVec[u]` pulses for exactly one cycle when unit u+1 holds an issued instruction and both of its sources are ready. A read is never raised in the issue cycle itself.
- R5: Several units waiting on the same register all read it in the same cycle, the one after its write-back.
- R6: A unit that reads in cycle r is eligible to write back from cycle r+L+1. L is 1, 10, 10, 2 or 40 for units 1 to 5.
- R7: A finished unit is held from write-back while another busy unit has a ready, still-unread source equal to its destination.
- R8: At most one write-back is granted per cycle. Among eligible units, the lowest identifier wins. `wbUnit` and `wbReg` give the unit and its destination.
- R9: A source whose producer writes back in the issue cycle is marked ready at once, so the new instruction reads in the next cycle.
- R10: After reset every unit is idle, `inReady` is high and no read or write-back strobe is raised.
- R11: A unit that writes back in cycle N can accept a new instruction in cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Decoded instruction present |
| inReady | output | 1 | Instruction can issue this cycle |
| inClass | input | 2 | Operation class (0 int, 1 mul, 2 add, 3 div) |
| inDest | input | 5 | Destination register |
| inSrcA | input | 5 | First source register |
| inSrcB | input | 5 | Second source register |
| issueUnit | output | 3 | Unit receiving the issued instruction, 0 if none |
| readVec | output | 5 | Per-unit operand read / execution start strobe |
| wbValid | output | 1 | A write-back is granted this cycle |
| wbUnit | output | 3 | Unit writing back |
| wbReg | output | 5 | Register being written |

## Verification
The assertions assume that the instruction fields stay stable while `inValid` is high and the instruction has not yet been accepted. They also assume the fields are meaningful whenever `inValid` is high. The bench drives each instruction from the falling edge and holds it until a cycle in which the reference model predicts acceptance. It may delay an instruction to a chosen cycle, which lets it line up an issue with a producer's write-back. Three programs are run: a mixed dependency chain with loads, multiplies, an add, a divide and a later add that overwrites a register still to be read; a sequence built around a write-after-write stall, a simultaneous finish and a same-cycle issue/write-back; and a burst of three multiplies that overruns the two multipliers.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU  = 5;
  localparam int REG_AW  = 5;
  localparam int NUM_REG = 1 << REG_AW;
  localparam int FU_IDW  = $clog2(NUM_FU + 1);
  localparam int CLS_W   = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_DIV = 2'd3
  } opClass_e;

  typedef logic [FU_IDW-1:0] fuId_t;
  typedef logic [REG_AW-1:0] regIdx_t;

  // one entry per execution unit
  typedef struct packed {
    logic     busy;
    logic     waitRd;
    opClass_e op;
    regIdx_t  dstReg;
    regIdx_t  srcA;
    regIdx_t  srcB;
    fuId_t    prodA;
    fuId_t    prodB;
    logic     rdyA;
    logic     rdyB;
  } fuEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              issueEn;
    fuId_t             issueId;
    logic [NUM_FU-1:0] readVec;
    logic              wbEn;
    fuId_t             wbId;
  } sbStrobe_t;

  // unit index -> class it serves (index 0 is identifier 1)
  function automatic opClass_e unitClass(input int u);
    opClass_e c;
    case (u)
      0:       c = CLS_INT;
      1, 2:    c = CLS_MUL;
      3:       c = CLS_ADD;
      default: c = CLS_DIV;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sbControl.sv
module sbControl
  import sb_pkg::*;
(
  input  logic                         inValid,
  input  logic [CLS_W-1:0]             inClass,
  input  regIdx_t                      inDest,
  input  fuEntry_t [NUM_FU-1:0]        fuTab,
  input  logic [NUM_REG-1:0][FU_IDW-1:0] resTab,
  input  logic [NUM_FU-1:0]            finVec,
  output logic                         inReady,
  output sbStrobe_t                    strobe
);
  fuId_t             freeId;
  logic              freeFound;
  logic              wawHit;
  logic [NUM_FU-1:0] warBlock;
  logic [NUM_FU-1:0] wbCand;
  logic [NUM_FU-1:0] wbOneHot;

  // lowest-numbered idle unit of the requested class
  always_comb begin : issue_sel
    freeFound = 1'b0;
    freeId    = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (!freeFound && !fuTab[u].busy && unitClass(u) == opClass_e'(inClass)) begin
        freeFound = 1'b1;
        freeId    = fuId_t'(u + 1);
      end
    end
  end

  assign wawHit  = resTab[inDest] != '0;
  assign inReady = freeFound && !wawHit;

  // a unit is held while someone still has to read the old value
  always_comb begin : war_scan
    for (int u = 0; u < NUM_FU; u++) begin
      warBlock[u] = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != u && fuTab[f].busy &&
            ((fuTab[f].rdyA && fuTab[f].srcA == fuTab[u].dstReg) ||
             (fuTab[f].rdyB && fuTab[f].srcB == fuTab[u].dstReg)))
          warBlock[u] = 1'b1;
      end
    end
  end

  assign wbCand   = finVec & ~warBlock;
  assign wbOneHot = wbCand & (~wbCand + NUM_FU'(1));

  always_comb begin : strobe_build
    strobe         = '0;
    strobe.issueEn = inValid && inReady;
    strobe.issueId = (inValid && inReady) ? freeId : '0;
    for (int u = 0; u < NUM_FU; u++)
      strobe.readVec[u] = fuTab[u].busy && fuTab[u].waitRd && fuTab[u].rdyA && fuTab[u].rdyB;
    strobe.wbEn = |wbOneHot;
    for (int u = 0; u < NUM_FU; u++)
      if (wbOneHot[u]) strobe.wbId = fuId_t'(u + 1);
  end
endmodule

// File: rtl/sbDatapath.sv
module sbDatapath
  import sb_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  sbStrobe_t                      strobe,
  input  logic [CLS_W-1:0]               inClass,
  input  regIdx_t                        inDest,
  input  regIdx_t                        inSrcA,
  input  regIdx_t                        inSrcB,
  output fuEntry_t [NUM_FU-1:0]          fuTab,
  output logic [NUM_REG-1:0][FU_IDW-1:0] resTab,
  output regIdx_t                        wbReg
);
  fuEntry_t newEntry;

  // entry for the instruction issuing now; a producer that retires
  // in this very cycle is treated as already done
  always_comb begin : entry_build
    newEntry        = '0;
    newEntry.busy   = 1'b1;
    newEntry.waitRd = 1'b1;
    newEntry.op     = opClass_e'(inClass);
    newEntry.dstReg = inDest;
    newEntry.srcA   = inSrcA;
    newEntry.srcB   = inSrcB;
    newEntry.prodA  = resTab[inSrcA];
    newEntry.prodB  = resTab[inSrcB];
    if (strobe.wbEn && newEntry.prodA == strobe.wbId) newEntry.prodA = '0;
    if (strobe.wbEn && newEntry.prodB == strobe.wbId) newEntry.prodB = '0;
    newEntry.rdyA   = newEntry.prodA == '0;
    newEntry.rdyB   = newEntry.prodB == '0;
  end

  always_comb begin : wb_reg_mux
    wbReg = '0;
    for (int u = 0; u < NUM_FU; u++)
      if (strobe.wbEn && strobe.wbId == fuId_t'(u + 1)) wbReg = fuTab[u].dstReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fuTab  <= '0;
      resTab <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        if (strobe.wbEn && fuTab[u].prodA == strobe.wbId) begin
          fuTab[u].prodA <= '0;
          fuTab[u].rdyA  <= 1'b1;
        end
        if (strobe.wbEn && fuTab[u].prodB == strobe.wbId) begin
          fuTab[u].prodB <= '0;
          fuTab[u].rdyB  <= 1'b1;
        end
        if (strobe.readVec[u]) begin
          fuTab[u].waitRd <= 1'b0;
          fuTab[u].rdyA   <= 1'b0;
          fuTab[u].rdyB   <= 1'b0;
        end
        if (strobe.wbEn && strobe.wbId == fuId_t'(u + 1))
          fuTab[u].busy <= 1'b0;
        if (strobe.issueEn && strobe.issueId == fuId_t'(u + 1))
          fuTab[u] <= newEntry;
      end
      if (strobe.wbEn)    resTab[wbReg]  <= '0;
      if (strobe.issueEn) resTab[inDest] <= strobe.issueId;
    end
  end
endmodule

// File: rtl/fuStub.sv
module fuStub #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic clear,
  output logic fin
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      if (start) begin
        cnt <= CW'(LAT);
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) fin <= 1'b1;
      end
      if (clear) fin <= 1'b0;
    end
  end
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard
  import sb_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CLS_W-1:0]  inClass,
  input  logic [REG_AW-1:0] inDest,
  input  logic [REG_AW-1:0] inSrcA,
  input  logic [REG_AW-1:0] inSrcB,
  output logic [FU_IDW-1:0] issueUnit,
  output logic [NUM_FU-1:0] readVec,
  output logic              wbValid,
  output logic [FU_IDW-1:0] wbUnit,
  output logic [REG_AW-1:0] wbReg
);
  sbStrobe_t                      strobe;
  fuEntry_t [NUM_FU-1:0]          fuTab;
  logic [NUM_REG-1:0][FU_IDW-1:0] resTab;
  logic [NUM_FU-1:0]              finVec;

  sbControl ctrl_i (
    .inValid (inValid),
    .inClass (inClass),
    .inDest  (inDest),
    .fuTab   (fuTab),
    .resTab  (resTab),
    .finVec  (finVec),
    .inReady (inReady),
    .strobe  (strobe)
  );

  sbDatapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inClass (inClass),
    .inDest  (inDest),
    .inSrcA  (inSrcA),
    .inSrcB  (inSrcB),
    .fuTab   (fuTab),
    .resTab  (resTab),
    .wbReg   (wbReg)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    localparam int UL = (u == 0) ? LAT_INT : (u < 3) ? LAT_MUL : (u == 3) ? LAT_ADD : LAT_DIV;
    fuStub #(.LAT(UL)) stub_i (
      .clk   (clk),
      .rstN  (rstN),
      .start (strobe.readVec[u]),
      .clear (strobe.wbEn && strobe.wbId == fuId_t'(u + 1)),
      .fin   (finVec[u])
    );
  end

  assign issueUnit = strobe.issueId;
  assign readVec   = strobe.readVec;
  assign wbValid   = strobe.wbEn;
  assign wbUnit    = strobe.wbId;
endmodule

// File: rtl/sbChecker.sv
module sbChecker
  import sb_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           inValid,
  input logic                           inReady,
  input regIdx_t                        inDest,
  input fuId_t                          issueUnit,
  input logic [NUM_FU-1:0]              readVec,
  input logic                           wbValid,
  input fuId_t                          wbUnit,
  input regIdx_t                        wbReg,
  input fuEntry_t [NUM_FU-1:0]          fuTab,
  input logic [NUM_REG-1:0][FU_IDW-1:0] resTab
);
  logic [NUM_FU-1:0] busyVec;
  logic              issueBusy;
  logic              warViol;

  always_comb begin
    issueBusy = 1'b0;
    warViol   = 1'b0;
    for (int u = 0; u < NUM_FU; u++) begin
      busyVec[u] = fuTab[u].busy;
      if (issueUnit == fuId_t'(u + 1) && fuTab[u].busy) issueBusy = 1'b1;
      if (wbValid && wbUnit != fuId_t'(u + 1) && fuTab[u].busy &&
          ((fuTab[u].rdyA && fuTab[u].srcA == wbReg) || (fuTab[u].rdyB && fuTab[u].srcB == wbReg)))
        warViol = 1'b1;
    end
  end

  // R2
  issue_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (issueUnit != '0 && !issueBusy));

  // R3
  dest_claimed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> resTab[$past(inDest)] == $past(issueUnit));

  // R4
  read_busy_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readVec & ~busyVec) == '0);

  // R7
  no_war_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !warViol);

  // R11
  release_after_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> resTab[$past(wbReg)] != $past(wbUnit));
endmodule

bind hazard_scoreboard sbChecker chk_i (.*);

// File: tb/hazard_scoreboard_tb_top.sv
module hazard_scoreboard_tb_top;
  import sb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 5;
  localparam int MAXP = 8;
  localparam int WD_LIMIT = 5000;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic [CLS_W-1:0] inClass = '0;
  logic [REG_AW-1:0] inDest = '0, inSrcA = '0, inSrcB = '0;
  logic inReady, wbValid;
  logic [FU_IDW-1:0] issueUnit, wbUnit;
  logic [NUM_FU-1:0] readVec;
  logic [REG_AW-1:0] wbReg;

  hazard_scoreboard dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int mBusy[NU], mPend[NU], mDst[NU], mSa[NU], mSb[NU], mPa[NU], mPb[NU];
  int mRa[NU], mRb[NU], mCnt[NU], mFin[NU], mOwner[NU];
  int mRes[32];
  int unitLat[NU] = '{1, 10, 10, 2, 40};
  int unitCls[NU] = '{0, 1, 1, 2, 3};

  int pCls[MAXP], pDst[MAXP], pSa[MAXP], pSb[MAXP], pAt[MAXP];
  int logIss[MAXP], logRd[MAXP], logWb[MAXP], logUnit[MAXP];
  int pCount, pIdx, cyc, tests, fails, wdCount;

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wdCount++;
    if (wdCount > WD_LIMIT) begin
      fails++;
      $display("FAIL R10 watchdog: actual=%0d expected<=%0d cycles", wdCount, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic addInstr(input int c, input int d, input int a, input int b, input int at);
    pCls[pCount] = c; pDst[pCount] = d; pSa[pCount] = a; pSb[pCount] = b; pAt[pCount] = at;
    logIss[pCount] = -1; logRd[pCount] = -1; logWb[pCount] = -1; logUnit[pCount] = -1;
    pCount++;
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0;
    inClass = '0; inDest = '0; inSrcA = '0; inSrcB = '0;
    repeat (3) @(negedge clk);
    for (int u = 0; u < NU; u++) begin
      mBusy[u] = 0; mPend[u] = 0; mPa[u] = 0; mPb[u] = 0; mRa[u] = 0; mRb[u] = 0;
      mCnt[u] = 0; mFin[u] = 0; mOwner[u] = 0; mDst[u] = 0; mSa[u] = 0; mSb[u] = 0;
    end
    for (int r = 0; r < 32; r++) mRes[r] = 0;
    // R10 reset state
    chkEq("R10", "inReady in reset", int'(inReady), 1);
    chkEq("R10", "readVec in reset", int'(readVec), 0);
    chkEq("R10", "wbValid in reset", int'(wbValid), 0);
    rstN = 1'b1;
    cyc = 0; pCount = 0; pIdx = 0;
  endtask

  task automatic stepCycle();
    int want, rdMask, wbU, expReady, fire, u;
    @(negedge clk);
    cyc++;
    if (pIdx < pCount && cyc >= pAt[pIdx]) begin
      inValid = 1'b1;
      inClass = CLS_W'(pCls[pIdx]); inDest = REG_AW'(pDst[pIdx]);
      inSrcA = REG_AW'(pSa[pIdx]); inSrcB = REG_AW'(pSb[pIdx]);
    end else begin
      inValid = 1'b0;
    end
    #1;
    want = 0;
    for (int k = 0; k < NU; k++)
      if (want == 0 && unitCls[k] == int'(inClass) && mBusy[k] == 0) want = k + 1;
    expReady = (want != 0 && mRes[int'(inDest)] == 0) ? 1 : 0;
    rdMask = 0;
    for (int k = 0; k < NU; k++)
      if (mBusy[k] != 0 && mPend[k] != 0 && mRa[k] != 0 && mRb[k] != 0) rdMask |= (1 << k);
    wbU = -1;
    for (int k = 0; k < NU; k++) begin
      bit held;
      held = 0;
      for (int f = 0; f < NU; f++)
        if (f != k && mBusy[f] != 0 &&
            ((mRa[f] != 0 && mSa[f] == mDst[k]) || (mRb[f] != 0 && mSb[f] == mDst[k]))) held = 1;
      if (wbU < 0 && mFin[k] != 0 && !held) wbU = k;
    end
    fire = (inValid && expReady != 0) ? 1 : 0;

    chkEq("R1", "inReady", int'(inReady), expReady);
    chkEq("R2", "issueUnit", int'(issueUnit), fire ? want : 0);
    chkEq("R4", "readVec", int'(readVec), rdMask);
    chkEq("R8", "wbValid", int'(wbValid), (wbU >= 0) ? 1 : 0);
    if (wbU >= 0) begin
      chkEq("R8", "wbUnit", int'(wbUnit), wbU + 1);
      chkEq("R8", "wbReg", int'(wbReg), mDst[wbU]);
    end

    // event log from observed outputs
    for (int k = 0; k < NU; k++)
      if (readVec[k]) logRd[mOwner[k]] = cyc;
    if (wbValid && wbUnit >= 1 && wbUnit <= NU) logWb[mOwner[int'(wbUnit) - 1]] = cyc;

    // advance the reference by one clock
    if (wbU >= 0) begin
      for (int f = 0; f < NU; f++) begin
        if (mPa[f] == wbU + 1) begin mPa[f] = 0; mRa[f] = 1; end
        if (mPb[f] == wbU + 1) begin mPb[f] = 0; mRb[f] = 1; end
      end
      mRes[mDst[wbU]] = 0; mBusy[wbU] = 0; mFin[wbU] = 0;
    end
    for (int k = 0; k < NU; k++)
      if (mCnt[k] > 0) begin mCnt[k]--; if (mCnt[k] == 0) mFin[k] = 1; end
    for (int k = 0; k < NU; k++)
      if (rdMask[k]) begin mPend[k] = 0; mRa[k] = 0; mRb[k] = 0; mCnt[k] = unitLat[k]; end
    if (fire != 0) begin
      u = want - 1;
      mBusy[u] = 1; mPend[u] = 1;
      mDst[u] = pDst[pIdx]; mSa[u] = pSa[pIdx]; mSb[u] = pSb[pIdx];
      mPa[u] = mRes[pSa[pIdx]]; mPb[u] = mRes[pSb[pIdx]];
      mRa[u] = (mPa[u] == 0) ? 1 : 0; mRb[u] = (mPb[u] == 0) ? 1 : 0;
      mRes[pDst[pIdx]] = want;
      mOwner[u] = pIdx;
      logIss[pIdx] = cyc; logUnit[pIdx] = want;
      pIdx++;
    end
  endtask

  task automatic runProg();
    for (int k = 0; k < 300; k++) begin
      bit idle;
      stepCycle();
      idle = 1;
      for (int f = 0; f < NU; f++) if (mBusy[f] != 0) idle = 0;
      if (pIdx == pCount && idle) break;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectEv(input int i, input int unit, input int iss, input int rd, input int wb, input string tag);
    chkEq(tag, $sformatf("instr%0d unit", i), logUnit[i], unit);
    chkEq(tag, $sformatf("instr%0d issue cycle", i), logIss[i], iss);
    chkEq(tag, $sformatf("instr%0d read cycle", i), logRd[i], rd);
    chkEq(tag, $sformatf("instr%0d write cycle", i), logWb[i], wb);
  endtask

  initial begin
    tests = 0; fails = 0; wdCount = 0;

    // mixed chain: load, load, mul, sub, div, add
    doReset();
    addInstr(0, 6, 22, 22, 1);
    addInstr(0, 2, 23, 23, 1);
    addInstr(1, 0, 2, 4, 1);
    addInstr(2, 8, 6, 2, 1);
    addInstr(3, 10, 0, 6, 1);
    addInstr(2, 6, 8, 2, 1);
    runProg();
    expectEv(0, 1, 1, 2, 4, "R6");
    expectEv(1, 1, 5, 6, 8, "R11");   // integer unit reused after write-back
    expectEv(2, 2, 6, 9, 20, "R5");   // reads alongside the sub in cycle 9
    expectEv(3, 4, 7, 9, 12, "R5");
    expectEv(4, 5, 8, 21, 62, "R6");
    expectEv(5, 4, 13, 14, 22, "R7"); // held until the divide has read reg 6

    // waw stall, simultaneous finish, same-cycle issue and write-back
    doReset();
    addInstr(2, 1, 5, 5, 1);
    addInstr(0, 7, 5, 5, 2);
    addInstr(1, 1, 3, 3, 3);
    addInstr(1, 9, 1, 4, 3);
    addInstr(2, 12, 9, 0, 31);
    runProg();
    expectEv(0, 4, 1, 2, 6, "R8");    // loses cycle 5 to the integer unit
    expectEv(1, 1, 2, 3, 5, "R8");
    expectEv(2, 2, 7, 8, 19, "R3");
    expectEv(3, 3, 8, 20, 31, "R4");
    expectEv(4, 4, 31, 32, 35, "R9");

    // three multiplies on two multipliers
    doReset();
    addInstr(1, 1, 4, 4, 1);
    addInstr(1, 2, 4, 4, 1);
    addInstr(1, 3, 4, 4, 1);
    runProg();
    expectEv(0, 2, 1, 2, 13, "R2");
    expectEv(1, 3, 2, 3, 14, "R2");
    expectEv(2, 2, 14, 15, 26, "R11");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule